// File: doc/BRIEF.md
# Multi-Port GPIO Pin Control Bank

This block is a memory-mapped general-purpose I/O controller. It groups pins into ports of eight. Each port has a small register window at a fixed address stride on a shared 32-bit register bus. Software writes an output data byte, a drive mode for each pin and a pull-up disable byte. The block turns these into per-pin output-enable, output-value and pull-up-enable signals for external pad cells. It also returns a synchronized copy of each pad's input level.

A global control word sits at address 0. It describes the bank: the number of ports and a version number. It also holds two writable enable bits. While the clock-request bit is clear, the whole pin bank is idle. Port writes are dropped and every output enable is held low, but the control word itself can still be written.

A two-state bus sequencer handles the register bus. In state IDLE it accepts one access per cycle; a write is applied at once. A read moves it to state RESP (transition IDLE->RESP), where the read data is presented for one cycle. It then always returns to IDLE (transition RESP->IDLE). Any request that arrives while it is in RESP is not accepted.

Top module: `gpio_bank`

## Requirements
- R1: After reset every port register reads 0, so every pin is an input (pad_oe 0) with the pull-up on (pad_pu 1) and pad_out 0. The control word's two enable bits read 0.
- R2: The control word at address 0x00 reads the port count in bits 15:9 and VERSION_ID in bits 8:2. Bit 1 (synchronizer select) and bit 0 (clock request) are writable, and all other bits read 0.
- R3: Port p occupies addresses p*0x30 + offset. The offsets are 0x04 for input level (read-only), 0x08 for output data (8 bits), 0x0C for drive mode (16 bits) and 0x10 for pull-up disable (8 bits). Unused bits read 0, and a write to one port leaves the other ports unchanged.
- R4: The mode field for pin i is bits 2i+1:2i of the mode register. Code 01 is push-pull: pad_oe is 1 and pad_out equals the data bit.
- R5: Mode code 10 is open-drain: pad_oe is 1 only when the data bit is 0.
- R6: Mode code 11 is open-source: pad_oe is 1 only when the data bit is 1.
- R7: Mode code 00 is input: pad_oe is 0 whatever the data bit.
- R8: pad_pu for a pin is the inverse of its pull-up disable bit.
- R9: The input level register returns pad_in through a two-flop synchronizer in every mode. A read accepted in the cycle right after pad_in changes still returns the old value. Writes to this register have no effect.
- R10: While the clock-request bit is 0, all pad_oe are 0 and port register writes are ignored. The control word remains writable.
- R11: A read accepted in IDLE (bus_sel=1, bus_wr=0, bus_ready=1) gives bus_rvalid=1 with the data in the next cycle, for exactly one cycle. During that cycle bus_ready is 0, and any request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Sequencer can accept a request |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| pad_in | input | 8*NUM_PORTS | Pad input levels |
| pad_oe | output | 8*NUM_PORTS | Pad output enables |
| pad_out | output | 8*NUM_PORTS | Pad output values |
| pad_pu | output | 8*NUM_PORTS | Pad pull-up enables |

## Verification
The assertions check the following on every cycle:
- the gating rule: no output enable while clock request is clear, and output values frozen across such a cycle;
- the sequencer's handshake: an accepted read is followed by a one-cycle valid during which ready is low.

Only the bench's scenarios can show the rest:
- the per-mode enable decoding;
- the address map and bit widths;
- the two-cycle input latency;
- that a request offered during RESP really leaves the registers untouched.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int PINS_PER_PORT = 8;
    localparam int MODE_W        = 2 * PINS_PER_PORT;

    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_LEVEL = 'h04;
    localparam int OFF_DATA  = 'h08;
    localparam int OFF_MODE  = 'h0C;
    localparam int OFF_PUD   = 'h10;

    typedef enum logic [1:0] {
        MODE_INPUT  = 2'b00,
        MODE_PUSH   = 2'b01,
        MODE_SINK   = 2'b10,
        MODE_SOURCE = 2'b11
    } pin_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [31:0] rd_mux,
    output logic        wr_stb,
    output logic        bus_ready,
    output logic        bus_rvalid,
    output logic [31:0] bus_rdata
);
    bus_state_e state_q, state_d;
    logic [31:0] rdata_q;
    logic        rd_accept;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_sel && !bus_wr) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_stb     = 1'b0;
        rd_accept  = 1'b0;
        bus_ready  = 1'b0;
        bus_rvalid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                bus_ready = 1'b1;
                wr_stb    = bus_sel && bus_wr;
                rd_accept = bus_sel && !bus_wr;
            end
            ST_RESP: bus_rvalid = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rdata_q <= '0;
        else if (rd_accept) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_bank_pkg::*;
#(
    parameter int PORT_IDX = 0,
    parameter int STRIDE   = 'h30,
    parameter int ADDR_W   = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     gate_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [31:0]              wdata,
    input  logic [PINS_PER_PORT-1:0] pad_in,
    output logic [31:0]              rd_data,
    output logic [PINS_PER_PORT-1:0] pad_oe,
    output logic [PINS_PER_PORT-1:0] pad_out,
    output logic [PINS_PER_PORT-1:0] pad_pu
);
    localparam int BASE = PORT_IDX * STRIDE;
    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(BASE + OFF_LEVEL);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(BASE + OFF_DATA);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(BASE + OFF_MODE);
    localparam logic [ADDR_W-1:0] A_PUD   = ADDR_W'(BASE + OFF_PUD);

    logic [PINS_PER_PORT-1:0] data_q, pud_q, lvl_s1, lvl_s2;
    logic [MODE_W-1:0]        mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            mode_q <= '0;
            pud_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_DATA) data_q <= wdata[PINS_PER_PORT-1:0];
            if (addr == A_MODE) mode_q <= wdata[MODE_W-1:0];
            if (addr == A_PUD)  pud_q  <= wdata[PINS_PER_PORT-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_s1 <= '0;
            lvl_s2 <= '0;
        end else begin
            lvl_s1 <= pad_in;
            lvl_s2 <= lvl_s1;
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == A_LEVEL) rd_data[PINS_PER_PORT-1:0] = lvl_s2;
        if (addr == A_DATA)  rd_data[PINS_PER_PORT-1:0] = data_q;
        if (addr == A_MODE)  rd_data[MODE_W-1:0]        = mode_q;
        if (addr == A_PUD)   rd_data[PINS_PER_PORT-1:0] = pud_q;
    end

    for (genvar i = 0; i < PINS_PER_PORT; i++) begin : g_pin
        logic drive;
        always_comb begin
            unique case (pin_mode_e'(mode_q[2*i +: 2]))
                MODE_INPUT:  drive = 1'b0;
                MODE_PUSH:   drive = 1'b1;
                MODE_SINK:   drive = !data_q[i];
                MODE_SOURCE: drive = data_q[i];
            endcase
        end
        assign pad_oe[i]  = drive && gate_en;
        assign pad_out[i] = data_q[i];
        assign pad_pu[i]  = !pud_q[i];
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int             NUM_PORTS  = 7,
    parameter int             STRIDE     = 'h30,
    parameter int             ADDR_W     = 9,
    parameter logic [6:0]     VERSION_ID = 7'd3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [31:0]                       bus_wdata,
    output logic                              bus_ready,
    output logic                              bus_rvalid,
    output logic [31:0]                       bus_rdata,
    input  logic [PINS_PER_PORT*NUM_PORTS-1:0] pad_in,
    output logic [PINS_PER_PORT*NUM_PORTS-1:0] pad_oe,
    output logic [PINS_PER_PORT*NUM_PORTS-1:0] pad_out,
    output logic [PINS_PER_PORT*NUM_PORTS-1:0] pad_pu
);
    localparam logic [6:0]        CORE_CNT = 7'(NUM_PORTS);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);

    logic        wr_stb, port_wr;
    logic        clkreq_q, syncsel_q;
    logic [31:0] port_rd [NUM_PORTS];
    logic [31:0] rd_mux;

    gpio_bus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .rd_mux     (rd_mux),
        .wr_stb     (wr_stb),
        .bus_ready  (bus_ready),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clkreq_q  <= 1'b0;
            syncsel_q <= 1'b0;
        end else if (wr_stb && bus_addr == A_CTRL) begin
            clkreq_q  <= bus_wdata[0];
            syncsel_q <= bus_wdata[1];
        end
    end

    assign port_wr = wr_stb && clkreq_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpio_port #(
            .PORT_IDX (p),
            .STRIDE   (STRIDE),
            .ADDR_W   (ADDR_W)
        ) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (port_wr),
            .gate_en (clkreq_q),
            .addr    (bus_addr),
            .wdata   (bus_wdata),
            .pad_in  (pad_in [p*PINS_PER_PORT +: PINS_PER_PORT]),
            .rd_data (port_rd[p]),
            .pad_oe  (pad_oe [p*PINS_PER_PORT +: PINS_PER_PORT]),
            .pad_out (pad_out[p*PINS_PER_PORT +: PINS_PER_PORT]),
            .pad_pu  (pad_pu [p*PINS_PER_PORT +: PINS_PER_PORT])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_CTRL)
            rd_mux = {16'd0, CORE_CNT, VERSION_ID, syncsel_q, clkreq_q};
        for (int p = 0; p < NUM_PORTS; p++) rd_mux = rd_mux | port_rd[p];
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int PIN_W = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             bus_ready,
    input logic             bus_rvalid,
    input logic             clk_req,
    input logic [PIN_W-1:0] pad_oe,
    input logic [PIN_W-1:0] pad_out
);
    p_gate_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_req |-> pad_oe == '0);

    p_gate_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_req |=> $stable(pad_out));

    p_read_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_ready) |=> bus_rvalid);

    p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid);

    p_busy_in_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> !bus_ready);
endmodule

bind gpio_bank gpio_bank_chk #(.PIN_W(8 * NUM_PORTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_ready  (bus_ready),
    .bus_rvalid (bus_rvalid),
    .clk_req    (clkreq_q),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
    localparam int NP = 7;
    localparam int PW = 8 * NP;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_ready, bus_rvalid;
    logic [31:0]   bus_rdata;
    logic [PW-1:0] pad_in = '0;
    logic [PW-1:0] pad_oe, pad_out, pad_pu;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    logic [15:0] m_mode [NP];
    logic [7:0]  m_data [NP];
    logic [7:0]  m_pud  [NP];
    bit          m_en;

    always #4 clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    function automatic logic [AW-1:0] ra(int p, int off);
        return AW'(p * 'h30 + off);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare read responses with the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected response actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(logic [AW-1:0] a, logic [31:0] e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        @(negedge clk);
    endtask

    task automatic mwrite(int p, int off, logic [31:0] d);
        bus_write(ra(p, off), d);
        if (m_en) begin
            if (off == 'h08) m_data[p] = d[7:0];
            if (off == 'h0C) m_mode[p] = d[15:0];
            if (off == 'h10) m_pud[p]  = d[7:0];
        end
    endtask

    task automatic check_pads(int p, string tag);
        logic [7:0] eo, ev, ep;
        for (int i = 0; i < 8; i++) begin
            case (m_mode[p][2*i +: 2])
                2'b00: eo[i] = 0;
                2'b01: eo[i] = 1;
                2'b10: eo[i] = !m_data[p][i];
                default: eo[i] = m_data[p][i];
            endcase
            if (!m_en) eo[i] = 0;
        end
        ev = m_data[p];
        ep = ~m_pud[p];
        check({tag, " oe"},  64'(pad_oe [p*8 +: 8]), 64'(eo));
        check({tag, " out"}, 64'(pad_out[p*8 +: 8]), 64'(ev));
        check({tag, " pu"},  64'(pad_pu [p*8 +: 8]), 64'(ep));
    endtask

    function automatic logic [31:0] ctrl_val(logic [1:0] en);
        return {16'd0, 7'(NP), 7'd3, en};
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_mode[p] = 0; m_data[p] = 0; m_pud[p] = 0;
        end
        m_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 oe", 64'(pad_oe), 64'(0));
        check("R1 pu", 64'(pad_pu), {{(64-PW){1'b0}}, {PW{1'b1}}});
        check("R1 out", 64'(pad_out), 64'(0));
        bus_read(ra(0, 0), ctrl_val(2'b00), "R1 R2 ctrl reset");
        bus_read(ra(3, 'h0C), 0, "R1 mode reset");

        // R10 writes ignored while clock request off
        mwrite(0, 'h08, 32'hFF);
        mwrite(0, 'h0C, 32'h5555);
        bus_read(ra(0, 'h08), 0, "R10 data ignored");
        bus_read(ra(0, 'h0C), 0, "R10 mode ignored");
        check("R10 oe", 64'(pad_oe), 64'(0));

        // R2 control register
        bus_write(ra(0, 0), 32'hFFFF_FFFF);
        bus_read(ra(0, 0), ctrl_val(2'b11), "R2 ctrl all ones");
        bus_write(ra(0, 0), 32'h1);
        bus_read(ra(0, 0), ctrl_val(2'b01), "R2 ctrl clkreq");
        m_en = 1;

        // R4-R7 mode decode on port 1: pins IN,PP,OD,OS,PP,OD,OS,IN
        mwrite(1, 'h0C, {16'hFFFF, 16'b00_11_10_01_11_10_01_00});
        mwrite(1, 'h08, 32'hA5);
        check_pads(1, "R4 R5 R6 R7 data A5");
        mwrite(1, 'h08, 32'hFFFF_FF5A);
        check_pads(1, "R4 R5 R6 R7 data 5A");
        mwrite(1, 'h0C, 32'h0000);
        check_pads(1, "R7 all input");
        mwrite(1, 'h0C, 32'hFFFF);
        check_pads(1, "R6 all source");
        mwrite(1, 'h0C, 32'hAAAA);
        check_pads(1, "R5 all sink");
        mwrite(1, 'h0C, {16'hFFFF, 16'b00_11_10_01_11_10_01_00});

        // R3 widths and addressing
        bus_read(ra(1, 'h08), 32'h5A, "R3 data width");
        bus_read(ra(1, 'h0C), 32'h39E4, "R3 mode width");
        mwrite(1, 'h10, 32'hFFFF_00F0);
        bus_read(ra(1, 'h10), 32'hF0, "R3 pud width");
        check_pads(1, "R8 pull-ups");
        mwrite(NP-1, 'h0C, 32'h5555);
        mwrite(NP-1, 'h08, 32'h3C);
        check_pads(NP-1, "R3 last port");
        check_pads(0, "R3 port0 untouched");
        check_pads(2, "R3 port2 untouched");
        bus_read(ra(2, 'h08), 0, "R3 other port data");

        // R9 input synchronizer
        pad_in[2*8 +: 8] = 8'hC3;
        pad_in[1*8 +: 8] = 8'h96;
        bus_read(ra(2, 'h04), 0, "R9 level latency");
        bus_read(ra(2, 'h04), 32'hC3, "R9 level port2");
        bus_read(ra(1, 'h04), 32'h96, "R9 level port1 output modes");
        bus_write(ra(2, 'h04), 32'h00);
        bus_read(ra(2, 'h04), 32'hC3, "R9 level write ignored");

        // R11 request during response is dropped
        exp_q.push_back(32'h5A);
        tag_q.push_back("R11 read");
        bus_sel = 1; bus_wr = 0; bus_addr = ra(1, 'h08);
        @(negedge clk);
        check("R11 ready low in resp", 64'(bus_ready), 64'(0));
        bus_wr = 1; bus_wdata = 32'h11;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        @(negedge clk);
        bus_read(ra(1, 'h08), 32'h5A, "R11 busy write dropped");
        check_pads(1, "R11 pads unchanged");

        // R10 gating again with live configuration
        bus_write(ra(0, 0), 32'h0);
        m_en = 0;
        check_pads(1, "R10 gated port1");
        check("R10 all oe", 64'(pad_oe), 64'(0));
        mwrite(1, 'h08, 32'h00);
        m_en = 1;
        bus_write(ra(0, 0), 32'h1);
        check_pads(1, "R10 restore");

        repeat (2) @(negedge clk);
        check("R11 queue drained", 64'(exp_q.size()), 64'(0));
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule